// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This controller turns the raw comparator flags of a regulated supply into a clean, active-low reset for a processor, plus an enable for the regulator pass device. It watches four conditions: the output falling below its trip level (93 % of nominal), the output rising back above its release level (95 % of nominal, giving 2 % of hysteresis), the die crossing its hot threshold or returning below its cool threshold, and the input supply sagging too low. Every flag and the delay-select pin pass through two-flop synchronizers before the state machine uses them.

A brief undervoltage dip is tolerated: the trip flag must stay set for a reaction window counted in microsecond ticks before reset is driven low. Once the supply is back above the release level, reset stays low for a release delay counted in millisecond ticks. The delay is one value of a fixed pair chosen by a build parameter, with the select pin choosing the member of the pair. The select pin is captured only while the controller sits in its reset-hold state. A hot die turns the output off and holds reset until the cool flag is seen, and then the normal release delay runs. A prescaler derives the microsecond tick from the system clock, so the same block serves any clock rate.

Top module: `supv_reset_timer`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sup_rst_n_o` is 0, `out_en_o` is 1 and `state_o` is 2 (reset hold). The first rise of `sup_rst_n_o` comes only after a full release delay has run.
- R2: `state_o` encodes NORMAL=0, UV_FILTER=1, RESET_HOLD=2, DELAY=3, THERMAL_OFF=4, and never shows any other value. `sup_rst_n_o` is 1 only in NORMAL and UV_FILTER.
- R3: `below_trip_i` high (output below 93 %) moves NORMAL to UV_FILTER. Reset asserts only when the flag stays high for REACT_US microsecond ticks. A shorter dip returns to NORMAL, and `sup_rst_n_o` stays 1 throughout.
- R4: Leaving RESET_HOLD needs `above_rel_i` high (output above 95 %) with `below_trip_i` and `vin_low_i` low. Clearing `below_trip_i` alone keeps reset asserted.
- R5: In DELAY, `sup_rst_n_o` rises after the selected number of milliseconds. If `above_rel_i` drops during the delay, the controller returns to RESET_HOLD and the full delay restarts.
- R6: The delay pair is set by VARIANT: 0 gives {8, 128} ms, 1 gives {8, 32} ms, 2 gives {16, 64} ms and 3 gives {32, 128} ms. `dly_sel_i` low picks the first value of the pair and high picks the second.
- R7: `dly_sel_i` is captured only in RESET_HOLD. A change during DELAY or NORMAL does not alter the delay being timed.
- R8: `therm_hot_i` high forces THERMAL_OFF from any state, with `out_en_o`=0 and `sup_rst_n_o`=0. The controller stays there until `therm_cool_i` is high, then goes through RESET_HOLD and a full release delay.
- R9: `vin_low_i` high forces RESET_HOLD from NORMAL, UV_FILTER or DELAY with no reaction filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| below_trip_i | input | 1 | Output is below the trip level (93 %) |
| above_rel_i | input | 1 | Output is above the release level (95 %) |
| therm_hot_i | input | 1 | Die is above the shutdown temperature |
| therm_cool_i | input | 1 | Die is below the shutdown temperature minus hysteresis |
| vin_low_i | input | 1 | Input supply is under its minimum |
| dly_sel_i | input | 1 | Picks the member of the delay pair |
| sup_rst_n_o | output | 1 | Active-low reset to the processor |
| out_en_o | output | 1 | Regulator output enable |
| state_o | output | 3 | Controller state code (see R2) |

## Verification
The bench walks the controller through a state sequence that a scoreboard predicts, and it times the reset release against both members of the delay pair. A dip shorter than the reaction window catches a design that skips the filter, because reset would fall. A supply parked between the trip and release levels catches a design with no hysteresis, because it would start the delay early. A release flag that drops mid-delay catches a design that does not restart the delay, because it would release early. A select change during the delay catches a design that samples the pin outside RESET_HOLD, because its release time would jump. A die held in the hysteresis band catches a design that recovers on the hot flag alone, because it would re-enable the output too soon.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_UV_FILTER = 3'd1,
    ST_RST_HOLD  = 3'd2,
    ST_DELAY     = 3'd3,
    ST_THERM_OFF = 3'd4
  } supv_state_e;

  localparam int unsigned MAX_DELAY_MS = 128;

  // Release delay in ms for a build variant and select level
  function automatic int unsigned pair_ms(input int unsigned variant, input logic sel);
    int unsigned r;
    case (variant)
      0:       r = sel ? 128 : 8;
      1:       r = sel ? 32  : 8;
      2:       r = sel ? 64  : 16;
      default: r = sel ? 128 : 32;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/supv_tick.sv
module supv_tick #(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic us_tick_o,
  output logic ms_tick_o
);
  localparam int unsigned PW = $clog2(CLK_PER_US + 1);
  localparam int unsigned SW = $clog2(US_PER_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(US_PER_MS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] sub_q, sub_d;

  assign us_tick_o = (pre_q == PRE_LAST);
  assign ms_tick_o = us_tick_o && (sub_q == SUB_LAST);

  always_comb begin
    pre_d = pre_q;
    sub_d = sub_q;
    if (clr_i) begin
      pre_d = '0;
      sub_d = '0;
    end else begin
      pre_d = us_tick_o ? '0 : pre_q + PW'(1);
      if (us_tick_o) begin
        sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end
endmodule

// File: rtl/supv_fsm.sv
module supv_fsm
  import supv_pkg::*;
#(
  parameter int unsigned VARIANT  = 0,
  parameter int unsigned REACT_US = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        below_i,
  input  logic        above_i,
  input  logic        hot_i,
  input  logic        cool_i,
  input  logic        vlow_i,
  input  logic        sel_i,
  input  logic        us_tick_i,
  input  logic        ms_tick_i,
  output logic        tmr_clr_o,
  output logic        sel_lat_o,
  output supv_state_e state_o
);
  localparam int unsigned RW = $clog2(REACT_US + 1);
  localparam int unsigned MW = $clog2(MAX_DELAY_MS + 1);
  localparam logic [RW-1:0] REACT_LIM = RW'(REACT_US);
  localparam logic [MW-1:0] DLY_LO    = MW'(pair_ms(VARIANT, 1'b0));
  localparam logic [MW-1:0] DLY_HI    = MW'(pair_ms(VARIANT, 1'b1));

  supv_state_e   state_q, state_d;
  logic [RW-1:0] react_q, react_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          sel_q, sel_d;
  logic [MW-1:0] dly_lim;
  logic          react_done, dly_done, clr;

  assign dly_lim    = sel_q ? DLY_HI : DLY_LO;
  assign react_done = (react_q == REACT_LIM);
  assign dly_done   = (ms_q == dly_lim);

  always_comb begin
    state_d = state_q;
    if (hot_i) begin
      state_d = ST_THERM_OFF;
    end else begin
      case (state_q)
        ST_NORMAL: begin
          if (vlow_i)       state_d = ST_RST_HOLD;
          else if (below_i) state_d = ST_UV_FILTER;
        end
        ST_UV_FILTER: begin
          if (vlow_i)          state_d = ST_RST_HOLD;
          else if (!below_i)   state_d = ST_NORMAL;
          else if (react_done) state_d = ST_RST_HOLD;
        end
        ST_RST_HOLD: begin
          if (above_i && !below_i && !vlow_i) state_d = ST_DELAY;
        end
        ST_DELAY: begin
          if (vlow_i || below_i || !above_i) state_d = ST_RST_HOLD;
          else if (dly_done)                 state_d = ST_NORMAL;
        end
        ST_THERM_OFF: begin
          if (cool_i) state_d = ST_RST_HOLD;
        end
        default: state_d = ST_RST_HOLD;
      endcase
    end
  end

  assign clr = (state_d != state_q);

  always_comb begin
    react_d = react_q;
    ms_d    = ms_q;
    if (clr) begin
      react_d = '0;
      ms_d    = '0;
    end else begin
      if (us_tick_i && !react_done) react_d = react_q + RW'(1);
      if (ms_tick_i && (ms_q != '1)) ms_d = ms_q + MW'(1);
    end
    sel_d = (state_q == ST_RST_HOLD) ? sel_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST_HOLD;
      react_q <= '0;
      ms_q    <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      react_q <= react_d;
      ms_q    <= ms_d;
      sel_q   <= sel_d;
    end
  end

  assign tmr_clr_o = clr;
  assign sel_lat_o = sel_q;
  assign state_o   = state_q;
endmodule

// File: rtl/supv_reset_timer.sv
module supv_reset_timer
  import supv_pkg::*;
#(
  parameter int unsigned VARIANT    = 0,
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned REACT_US   = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_trip_i,
  input  logic       above_rel_i,
  input  logic       therm_hot_i,
  input  logic       therm_cool_i,
  input  logic       vin_low_i,
  input  logic       dly_sel_i,
  output logic       sup_rst_n_o,
  output logic       out_en_o,
  output logic [2:0] state_o
);
  localparam int unsigned NSYNC = 6;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic below_s, above_s, hot_s, cool_s, vlow_s, sel_s;
  logic us_tick, ms_tick, tmr_clr, sel_lat;
  supv_state_e st;

  assign raw_in = {dly_sel_i, vin_low_i, therm_cool_i, therm_hot_i, above_rel_i, below_trip_i};

  supv_sync #(.WIDTH(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign {sel_s, vlow_s, cool_s, hot_s, above_s, below_s} = syn_in;

  supv_tick #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
    .us_tick_o(us_tick), .ms_tick_o(ms_tick)
  );

  supv_fsm #(.VARIANT(VARIANT), .REACT_US(REACT_US)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .below_i(below_s), .above_i(above_s), .hot_i(hot_s), .cool_i(cool_s),
    .vlow_i(vlow_s), .sel_i(sel_s),
    .us_tick_i(us_tick), .ms_tick_i(ms_tick),
    .tmr_clr_o(tmr_clr), .sel_lat_o(sel_lat), .state_o(st)
  );

  assign sup_rst_n_o = (st == ST_NORMAL) || (st == ST_UV_FILTER);
  assign out_en_o    = (st != ST_THERM_OFF);
  assign state_o     = st;
endmodule

// File: rtl/supv_reset_timer_chk.sv
module supv_reset_timer_chk
  import supv_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       rst_o,
  input logic       out_en,
  input logic       hot_s,
  input logic       vlow_s,
  input logic       above_s,
  input logic       sel_q
);
  // R2: only the five defined state codes appear
  always @(posedge clk) begin
    if (rst_n) a_r2_legal_state: assert (state <= 3'd4);
  end

  // R3: NORMAL never drops straight to reset hold without a forcing flag
  a_r3_no_skip_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && !vlow_s && !hot_s) |=> (state != ST_RST_HOLD));

  // R4: hold is kept while the release flag is low
  a_r4_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RST_HOLD && !above_s) |=> (state == ST_RST_HOLD || state == ST_THERM_OFF));

  // R5: reset is released only out of the delay state
  a_r5_release_from_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> ($past(state) == ST_DELAY));

  // R7: captured select changes only in reset hold
  a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RST_HOLD) |=> $stable(sel_q));

  // R8: hot die turns the output off and asserts reset next cycle
  a_r8_therm_off: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> (!out_en && !rst_o));
endmodule

bind supv_reset_timer supv_reset_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_o), .rst_o(sup_rst_n_o), .out_en(out_en_o),
  .hot_s(hot_s), .vlow_s(vlow_s), .above_s(above_s), .sel_q(sel_lat)
);

// File: tb/test_supv_reset_timer.sv
module test_supv_reset_timer;
  localparam int CPU = 2;
  localparam int UPM = 40;
  localparam int CYC_MS = CPU * UPM;
  localparam logic [2:0] S_NORM = 3'd0, S_UV = 3'd1, S_HOLD = 3'd2, S_DLY = 3'd3, S_THERM = 3'd4;

  logic clk, rst_n;
  logic below, above, hot, cool, vlow, sel;
  logic rst_o, en_o;
  logic [2:0] st_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  logic [2:0] prev_st;

  supv_reset_timer #(.VARIANT(0), .CLK_PER_US(CPU), .US_PER_MS(UPM), .REACT_US(25)) i_supv_reset_timer (
    .clk(clk), .rst_n(rst_n), .below_trip_i(below), .above_rel_i(above),
    .therm_hot_i(hot), .therm_cool_i(cool), .vin_low_i(vlow), .dly_sel_i(sel),
    .sup_rst_n_o(rst_o), .out_en_o(en_o), .state_o(st_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] s);
    exp_q.push_back(s);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each state change with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (st_o != prev_st) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected state change", int'(st_o), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk(st_o == e, "R2 state sequence", int'(st_o), int'(e));
        end
        prev_st = st_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; below = 1; above = 0; hot = 0; cool = 1; vlow = 0; sel = 0;
    prev_st = S_HOLD;
    wait_cyc(5);
    // R1 reset state
    chk(rst_o == 0, "R1 reset out", rst_o, 0);
    chk(en_o == 1, "R1 out_en", en_o, 1);
    chk(st_o == S_HOLD, "R1 state", st_o, S_HOLD);
    rst_n = 1;
    wait_cyc(5);
    chk(st_o == S_HOLD && rst_o == 0, "R1 hold after reset", rst_o, 0);

    // R1/R6 power-on release, select low -> 8 ms
    push(S_DLY); push(S_NORM);
    below = 0; above = 1;
    wait_cyc(8 * CYC_MS - 20);
    chk(rst_o == 0, "R1 full delay before first release", rst_o, 0);
    wait_cyc(60);
    chk(rst_o == 1, "R6 release after 8 ms", rst_o, 1);

    // R3 short dip is filtered
    push(S_UV); push(S_NORM);
    below = 1; above = 0;
    wait_cyc(20);
    chk(rst_o == 1, "R3 short dip reset stays high", rst_o, 1);
    below = 0; above = 1;
    wait_cyc(10);
    chk(rst_o == 1 && st_o == S_NORM, "R3 back to normal", st_o, S_NORM);

    // R3 long dip asserts reset
    push(S_UV); push(S_HOLD);
    below = 1; above = 0;
    wait_cyc(30);
    chk(rst_o == 1, "R3 reset high inside reaction window", rst_o, 1);
    wait_cyc(70);
    chk(rst_o == 0, "R3 reset low after reaction time", rst_o, 0);

    // R4 between trip and release levels: hold continues
    below = 0;
    wait_cyc(200);
    chk(rst_o == 0 && st_o == S_HOLD, "R4 hysteresis hold", st_o, S_HOLD);

    // R6 select high -> 128 ms
    sel = 1;
    wait_cyc(10);
    push(S_DLY); push(S_NORM);
    above = 1;
    wait_cyc(128 * CYC_MS - 40);
    chk(rst_o == 0, "R6 long delay not yet over", rst_o, 0);
    wait_cyc(80);
    chk(rst_o == 1, "R6 release after 128 ms", rst_o, 1);

    // R5 restart on drop during delay
    sel = 0;
    push(S_UV); push(S_HOLD);
    below = 1; above = 0;
    wait_cyc(100);
    below = 0;
    wait_cyc(10);
    push(S_DLY);
    above = 1;
    wait_cyc(300);
    push(S_HOLD);
    above = 0;
    wait_cyc(20);
    chk(st_o == S_HOLD, "R5 drop returns to hold", st_o, S_HOLD);
    push(S_DLY); push(S_NORM);
    above = 1;
    wait_cyc(8 * CYC_MS - 20);
    chk(rst_o == 0, "R5 delay restarted", rst_o, 0);
    wait_cyc(60);
    chk(rst_o == 1, "R5 release after restarted delay", rst_o, 1);

    // R9 input undervoltage forces hold without filter; R7 select change in delay ignored
    push(S_HOLD);
    vlow = 1;
    wait_cyc(5);
    chk(rst_o == 0 && st_o == S_HOLD, "R9 vin low immediate reset", rst_o, 0);
    wait_cyc(10);
    push(S_DLY); push(S_NORM);
    vlow = 0;
    wait_cyc(100);
    sel = 1;
    wait_cyc(8 * CYC_MS - 120);
    chk(rst_o == 0, "R7 delay before 8 ms", rst_o, 0);
    wait_cyc(60);
    chk(rst_o == 1, "R7 select change in delay ignored", rst_o, 1);

    // R7 select change in normal has no effect on output
    sel = 0;
    wait_cyc(20);
    chk(rst_o == 1 && st_o == S_NORM, "R7 select change in normal", st_o, S_NORM);

    // R8 thermal shutdown
    push(S_THERM);
    hot = 1; cool = 0;
    wait_cyc(5);
    chk(en_o == 0, "R8 output disabled", en_o, 0);
    chk(rst_o == 0, "R8 reset asserted", rst_o, 0);
    hot = 0;
    wait_cyc(200);
    chk(st_o == S_THERM && en_o == 0, "R8 hysteresis band stays off", st_o, S_THERM);
    push(S_HOLD); push(S_DLY); push(S_NORM);
    cool = 1;
    wait_cyc(10);
    chk(en_o == 1 && rst_o == 0, "R8 recovering, reset still low", rst_o, 0);
    wait_cyc(8 * CYC_MS - 30);
    chk(rst_o == 0, "R8 release delay running", rst_o, 0);
    wait_cyc(60);
    chk(rst_o == 1, "R8 release after delay", rst_o, 1);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule